// File: doc/BRIEF.md
# Multi-CPU Interrupt Controller Core

This block collects a configurable number of level-sensitive interrupt sources and delivers them to up to four CPUs. Each CPU has one interrupt output. A source reaches CPU k only when four conditions hold: the source is asserted, it is globally enabled, its routing word selects k, and CPU k has not masked it. Source 0 carries the inter-processor doorbell summary and is treated like any other source. One source, chosen by parameter, is a private per-CPU source. For that source the routing word is ignored, and each CPU's mask alone decides delivery.

Software reaches two register banks over a simple register bus. The `bus_priv` input selects between them. The global bank holds the implemented-source count, the set-enable and clear-enable ports, and one routing word per source. The per-CPU bank holds the mask-set port, the mask-clear port and the acknowledge register. The `bus_cpu` sideband input names the CPU making the access and is sampled together with the request. An acknowledge read returns the lowest-numbered source pending for that CPU. It does not change any state, because the sources are level-sensitive.

Top module: `cpu_irq_hub`

## Requirements
- R1: After reset, every global enable is clear, every source is masked for every CPU, every routing word is zero, `cpu_irq` is all zero and `bus_rdata` is zero.
- R2: A write of source number n (in `bus_wdata[9:0]`) to global offset 0x30 sets the enable of n, and a write to 0x34 clears it. No other source changes. A number at or above NSRC changes nothing.
- R3: A write of n to per-CPU offset 0x48 masks n for the CPU named on `bus_cpu`, and a write to 0x4C unmasks it. The masks of the other CPUs are unchanged.
- R4: The routing word of source n is at global offset 0x100 + 4*n. Its bits [NCPU-1:0] hold the target CPU bitmask. A read returns those bits, with the upper bits zero.
- R5: `cpu_irq[k]` is high in the same cycle as any source that is asserted, enabled, routed to k and unmasked by k. It needs no clock edge once the registers are set.
- R6: A read of per-CPU offset 0x44 returns, in bits [9:0], the lowest-numbered source that qualifies for the reading CPU. Bits above 9 are zero. Read data appears in the cycle after the request edge.
- R7: When no source qualifies for the reading CPU, the acknowledge read returns 1023.
- R8: A read of global offset 0x00 returns NSRC in bits [11:2].
- R9: The per-CPU source (PCPU_SRC) ignores its routing word. It reaches CPU k when it is asserted, enabled and unmasked by k.
- R10: An acknowledge read does not clear anything. A repeated read returns the same source while that source stays asserted, and the next source once it drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NSRC | Level interrupt sources, bit n is source n |
| bus_req | input | 1 | Register access request, one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = per-CPU bank, 0 = global bank |
| bus_cpu | input | CW | Index of the CPU making the access |
| bus_addr | input | AW | Byte offset within the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| cpu_irq | output | NCPU | Interrupt line per CPU |

## Verification
Register writes take effect at the request edge. From then on, `cpu_irq` follows the sources combinationally, so the bench checks the line one time step after it changes a source level, with no clock edge in between. Read data is registered at the request edge. The bench drops the request on the next falling edge and samples `bus_rdata` there. Priority, masking per CPU and the private source are each set up from reset, so no state is carried over from one scenario to the next.

// File: rtl/cpu_irq_hub.sv
module cpu_irq_hub #(
  parameter int NCPU     = 4,
  parameter int NSRC     = 32,
  parameter int PCPU_SRC = 5,
  parameter int AW       = 12,
  localparam int CW      = (NCPU > 1) ? $clog2(NCPU) : 1,
  localparam int RIW     = AW - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_lvl,
  input  logic            bus_req,
  input  logic            bus_we,
  input  logic            bus_priv,
  input  logic [CW-1:0]   bus_cpu,
  input  logic [AW-1:0]   bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic [NCPU-1:0] cpu_irq
);
  localparam logic [AW-1:0] A_CTRL  = AW'(12'h000);
  localparam logic [AW-1:0] A_ENSET = AW'(12'h030);
  localparam logic [AW-1:0] A_ENCLR = AW'(12'h034);
  localparam logic [AW-1:0] A_ACK   = AW'(12'h044);
  localparam logic [AW-1:0] A_MSET  = AW'(12'h048);
  localparam logic [AW-1:0] A_MCLR  = AW'(12'h04C);

  logic [NSRC-1:0]            en_q;
  logic [NCPU-1:0][NSRC-1:0]  mask_q;
  logic [NSRC-1:0][NCPU-1:0]  route_q;
  logic [NCPU-1:0][NSRC-1:0]  qual;
  logic [NCPU-1:0][9:0]       sel_id;
  logic [NSRC-1:0]            id_hit;
  logic [RIW-1:0]             ridx;
  logic                       in_route;
  logic [31:0]                rd_val;

  wire wr_g = bus_req &  bus_we & ~bus_priv;
  wire wr_p = bus_req &  bus_we &  bus_priv;
  wire rd_g = bus_req & ~bus_we & ~bus_priv;
  wire rd_p = bus_req & ~bus_we &  bus_priv;

  assign ridx     = bus_addr[AW-1:2] - RIW'(64);
  assign in_route = (bus_addr[AW-1:2] >= RIW'(64)) && ({{(32-RIW){1'b0}}, ridx} < NSRC)
                    && (bus_addr[1:0] == 2'b00);

  always_comb
    for (int n = 0; n < NSRC; n++) id_hit[n] = (bus_wdata[9:0] == 10'(n));

  always_comb begin
    for (int k = 0; k < NCPU; k++) begin
      sel_id[k] = 10'h3FF;
      for (int n = NSRC - 1; n >= 0; n--) begin
        qual[k][n] = src_lvl[n] & en_q[n] & ~mask_q[k][n] &
                     ((n == PCPU_SRC) ? 1'b1 : route_q[n][k]);
        if (qual[k][n]) sel_id[k] = 10'(n);
      end
    end
  end

  always_comb
    for (int k = 0; k < NCPU; k++) cpu_irq[k] = |qual[k];

  always_comb begin
    rd_val = 32'h0;
    if (rd_g) begin
      if (bus_addr == A_CTRL) rd_val[11:2] = 10'(NSRC);
      else if (in_route)
        for (int n = 0; n < NSRC; n++)
          if (ridx == RIW'(n)) rd_val[NCPU-1:0] = route_q[n];
    end else if (rd_p && bus_addr == A_ACK) begin
      for (int k = 0; k < NCPU; k++)
        if (bus_cpu == CW'(k)) rd_val[9:0] = sel_id[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      mask_q    <= '1;
      route_q   <= '0;
      bus_rdata <= 32'h0;
    end else begin
      if (bus_req && !bus_we) bus_rdata <= rd_val;
      if (wr_g && bus_addr == A_ENSET) en_q <= en_q | id_hit;
      if (wr_g && bus_addr == A_ENCLR) en_q <= en_q & ~id_hit;
      if (wr_g && in_route)
        for (int n = 0; n < NSRC; n++)
          if (ridx == RIW'(n)) route_q[n] <= bus_wdata[NCPU-1:0];
      for (int k = 0; k < NCPU; k++) begin
        if (wr_p && bus_cpu == CW'(k) && bus_addr == A_MSET) mask_q[k] <= mask_q[k] | id_hit;
        if (wr_p && bus_cpu == CW'(k) && bus_addr == A_MCLR) mask_q[k] <= mask_q[k] & ~id_hit;
      end
    end
  end
endmodule

// File: rtl/cpu_irq_hub_chk.sv
module cpu_irq_hub_chk #(
  parameter int NCPU = 4,
  parameter int NSRC = 32,
  parameter int AW   = 12,
  localparam int CW  = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NSRC-1:0]           src_lvl,
  input logic                      bus_req,
  input logic                      bus_we,
  input logic                      bus_priv,
  input logic [CW-1:0]             bus_cpu,
  input logic [AW-1:0]             bus_addr,
  input logic [31:0]               bus_wdata,
  input logic [31:0]               bus_rdata,
  input logic [NCPU-1:0]           cpu_irq,
  input logic [NSRC-1:0]           en_q,
  input logic [NCPU-1:0][NSRC-1:0] mask_q
);
  logic [NSRC-1:0] wsel;
  always_comb
    for (int n = 0; n < NSRC; n++) wsel[n] = (bus_wdata[9:0] == 10'(n));

  wire g_wr = bus_req & bus_we & ~bus_priv;
  wire p_wr = bus_req & bus_we & bus_priv;
  wire g_rd = bus_req & ~bus_we & ~bus_priv;
  wire p_rd = bus_req & ~bus_we & bus_priv;

  AST_ENABLE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (g_wr && bus_addr == AW'(12'h030)) |=> ((en_q & $past(wsel)) == $past(wsel))); // R2
  AST_ENABLE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (g_wr && bus_addr == AW'(12'h034)) |=> ((en_q & $past(wsel)) == '0)); // R2
  AST_CTRL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (g_rd && bus_addr == AW'(12'h000)) |=> (bus_rdata[11:2] == 10'(NSRC))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (src_lvl == '0) |-> (cpu_irq == '0)); // R5

  for (genvar k = 0; k < NCPU; k++) begin : g_cpu
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (p_wr && bus_cpu == CW'(k) && bus_addr == AW'(12'h048)) |=>
      ((mask_q[k] & $past(wsel)) == $past(wsel))); // R3
    AST_ACK_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (p_rd && bus_cpu == CW'(k) && bus_addr == AW'(12'h044) && !cpu_irq[k]) |=>
      (bus_rdata == 32'd1023)); // R7
  end
endmodule

bind cpu_irq_hub cpu_irq_hub_chk #(.NCPU(NCPU), .NSRC(NSRC), .AW(AW)) u_chk (.*);

// File: tb/cpu_irq_hub_tb.sv
module cpu_irq_hub_tb;
  localparam int NCPU = 4;
  localparam int NSRC = 32;
  localparam int AW   = 12;

  logic            clk = 0;
  logic            rst_n = 0;
  logic [NSRC-1:0] src_lvl = '0;
  logic            bus_req = 0, bus_we = 0, bus_priv = 0;
  logic [1:0]      bus_cpu = '0;
  logic [AW-1:0]   bus_addr = '0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NCPU-1:0] cpu_irq;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #2.5 clk = ~clk;

  cpu_irq_hub #(.NCPU(NCPU), .NSRC(NSRC), .PCPU_SRC(5), .AW(AW)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    src_lvl = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic acc(logic we, logic priv, logic [1:0] cpu, logic [AW-1:0] a,
                     logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_priv = priv; bus_cpu = cpu; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
    q = bus_rdata;
  endtask

  task automatic wr(logic priv, logic [1:0] cpu, logic [AW-1:0] a, logic [31:0] d);
    logic [31:0] dummy;
    acc(1, priv, cpu, a, d, dummy);
  endtask

  task automatic ack(logic [1:0] cpu, output logic [31:0] q);
    acc(0, 1, cpu, 12'h044, 0, q);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq", 32'(cpu_irq), 0);
    chk("R1 rdata", bus_rdata, 0);
    acc(0, 0, 0, 12'h10C, 0, rv);
    chk("R1 route", rv, 0);
    src_lvl = '1;
    #1 chk("R1 masked", 32'(cpu_irq), 0);
    ack(0, rv);
    chk("R7 none", rv, 1023);
  endtask

  task automatic t_ctrl();
    do_reset();
    acc(0, 0, 0, 12'h000, 0, rv);
    chk("R8 count", rv, 32'(NSRC) << 2);
  endtask

  task automatic t_basic();
    do_reset();
    src_lvl[7] = 1;
    wr(0, 0, 12'h11C, 32'h1);
    wr(0, 0, 12'h030, 7);
    #1 chk("R3 still masked", 32'(cpu_irq), 0);
    wr(1, 0, 12'h04C, 7);
    #1 chk("R5 cpu0", 32'(cpu_irq), 32'h1);
    ack(0, rv);
    chk("R6 id7", rv, 7);
    ack(1, rv);
    chk("R7 other cpu", rv, 1023);
    src_lvl[7] = 0;
    #1 chk("R5 drop", 32'(cpu_irq), 0);
  endtask

  task automatic t_prio();
    do_reset();
    src_lvl[7] = 1; src_lvl[3] = 1;
    wr(0, 0, 12'h11C, 1); wr(0, 0, 12'h10C, 1);
    wr(0, 0, 12'h030, 7); wr(0, 0, 12'h030, 3);
    wr(1, 0, 12'h04C, 7); wr(1, 0, 12'h04C, 3);
    ack(0, rv); chk("R6 lowest", rv, 3);
    ack(0, rv); chk("R10 repeat", rv, 3);
    src_lvl[3] = 0;
    ack(0, rv); chk("R10 next", rv, 7);
    src_lvl[3] = 1;
    wr(0, 0, 12'h034, 7);
    ack(0, rv); chk("R2 clr other kept", rv, 3);
    wr(0, 0, 12'h034, 3);
    wr(0, 0, 12'h030, 40);
    ack(0, rv); chk("R2 out of range", rv, 1023);
    #1 chk("R2 irq off", 32'(cpu_irq), 0);
  endtask

  task automatic t_mask();
    do_reset();
    src_lvl[9] = 1;
    wr(0, 0, 12'h124, 32'h5);
    wr(0, 0, 12'h030, 9);
    wr(1, 2, 12'h04C, 9);
    #1 chk("R3 cpu2 only", 32'(cpu_irq), 32'h4);
    wr(1, 0, 12'h04C, 9);
    #1 chk("R3 cpu0 too", 32'(cpu_irq), 32'h5);
    wr(1, 2, 12'h048, 9);
    #1 chk("R3 remask cpu2", 32'(cpu_irq), 32'h1);
  endtask

  task automatic t_pcpu();
    do_reset();
    src_lvl[5] = 1;
    wr(0, 0, 12'h030, 5);
    wr(1, 1, 12'h04C, 5); wr(1, 3, 12'h04C, 5);
    #1 chk("R9 private", 32'(cpu_irq), 32'hA);
    ack(3, rv); chk("R9 ack", rv, 5);
  endtask

  task automatic t_route();
    do_reset();
    wr(0, 0, 12'h130, 32'hFFFF_FFFF);
    acc(0, 0, 0, 12'h130, 0, rv);
    chk("R4 readback", rv, 32'hF);
    acc(0, 0, 0, 12'h134, 0, rv);
    chk("R4 neighbour", rv, 0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_ctrl(); t_basic(); t_prio(); t_mask(); t_pcpu(); t_route();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule